// File: doc/BRIEF.md
# Overlaid Internal RAM / Special-Register Decoder

This block holds the internal scratch RAM of a small controller and steers each data access either into that RAM or out to a special-register port. The address space is split in half. Accesses to the lower half always land in RAM. The upper half is shared by two physically separate stores. A request marked indirect (pointer-based accesses, including stack pushes and pops) reaches the upper RAM bytes. A request marked direct reaches the special-register port instead. Because of this, the stack can grow into the upper RAM without disturbing a port register that shares its address.

Only a fixed subset of the special-register addresses is populated, and a parameter mask names that subset. For a direct access to an unpopulated address, no strobe goes to the register port: a write is dropped, and a read returns zero, so the result is repeatable. Read data from either store appears one clock after the read strobe, with a valid pulse.

Top module: `iram_overlay`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is 00H.
- R2: Addresses 00H–7FH reach the lower RAM in both modes: a byte written in one mode reads back in the other, and neither `sfr_rd` nor `sfr_wr` is asserted.
- R3: An indirect access (`req_indirect`=1) to 80H–FFH reaches the upper RAM and asserts no register-port strobe.
- R4: A direct write (`req_indirect`=0) to a populated address in 80H–FFH asserts `sfr_wr` with `sfr_addr` equal to the request address and `sfr_wdata` equal to the write data, and leaves the upper RAM byte at that address unchanged.
- R5: `rd_valid` is high exactly in the cycle after a cycle with `req_rd`=1, and `rd_data` is valid in that cycle.
- R6: A direct access to an unpopulated address in 80H–FFH asserts neither strobe, and its read returns 00H. With the default mask, the populated addresses are 80H, 81H, 90H, A0H, B0H, D0H, E0H and F0H.
- R7: When a read and a write hit the same RAM address in the same cycle, the read returns the old byte, and the new byte is returned by the next read.
- R8: A direct read of a populated address asserts `sfr_rd` and returns the `sfr_rdata` value that was present in the cycle of the request.
- R9: All 128 upper RAM bytes hold distinct values when filled by indirect writes, as a stack does, and each byte reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_addr | input | 8 | Access address |
| req_indirect | input | 1 | 1 = indirect (pointer/stack) access, 0 = direct access |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `req_rd` |
| rd_data | output | 8 | Read data |
| sfr_addr | output | 8 | Special-register port address |
| sfr_rd | output | 1 | Special-register read strobe |
| sfr_wr | output | 1 | Special-register write strobe |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_rdata | input | 8 | Special-register read data, sampled in the request cycle |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 8-bit data, and a mask that populates eight register addresses. With these values the whole 256-byte RAM is small enough to exercise completely. The bench fills every upper byte through indirect writes and reads each one back, and it compares direct and indirect traffic at the same address (A0H). Both the populated and the unpopulated register cases are reached at real addresses.

// File: rtl/iram_pkg.sv
package iram_pkg;

  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_REG  = 2'd1,
    TGT_VOID = 2'd2
  } tgt_e;

  // Pick the store for one access. The upper half is shared by the
  // upper RAM and the register window; the access mode decides which.
  function automatic tgt_e route_of(input logic upper, input logic indirect,
                                    input logic populated);
    if (!upper || indirect) return TGT_RAM;
    else if (populated)     return TGT_REG;
    else                    return TGT_VOID;
  endfunction

endpackage

// File: rtl/iram_route.sv
module iram_route
  import iram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [(1<<(ADDR_W-1))-1:0] POP_MASK = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              indirect,
  output tgt_e              tgt,
  output logic              hit
);
  localparam int OFS_W = ADDR_W - 1;

  logic upper;
  logic [OFS_W-1:0] ofs;

  assign upper = addr[ADDR_W-1];
  assign ofs   = addr[OFS_W-1:0];
  assign hit   = upper && POP_MASK[ofs];
  assign tgt   = route_of(upper, indirect, hit);
endmodule

// File: rtl/iram_bank.sv
module iram_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read returns the stored byte before any same-cycle write lands.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/iram_rsp.sv
module iram_rsp
  import iram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  tgt_e              tgt,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  tgt_e              tgt_q;
  logic [DATA_W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tgt_q <= TGT_VOID;
      reg_q <= '0;
    end else begin
      valid <= rd;
      if (rd) begin
        tgt_q <= tgt;
        reg_q <= (tgt == TGT_REG) ? reg_rdata : '0;
      end
    end
  end

  always_comb begin
    data = '0;
    if (valid) begin
      unique case (tgt_q)
        TGT_RAM: data = ram_rdata;
        TGT_REG: data = reg_q;
        default: data = '0;
      endcase
    end
  end
endmodule

// File: rtl/iram_overlay.sv
module iram_overlay
  import iram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [(1<<(ADDR_W-1))-1:0] POP_MASK =
    (128'd1 << 0)  | (128'd1 << 1)  | (128'd1 << 16) | (128'd1 << 32) |
    (128'd1 << 48) | (128'd1 << 80) | (128'd1 << 96) | (128'd1 << 112)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_indirect,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic              sfr_rd,
  output logic              sfr_wr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata
);
  tgt_e              tgt_w;
  logic              sfr_hit_w;
  logic              ram_sel_w;
  logic              reg_sel_w;
  logic [DATA_W-1:0] ram_q;

  iram_route #(.ADDR_W(ADDR_W), .POP_MASK(POP_MASK)) u_route (
    .addr     (req_addr),
    .indirect (req_indirect),
    .tgt      (tgt_w),
    .hit      (sfr_hit_w)
  );

  assign ram_sel_w = (tgt_w == TGT_RAM);
  assign reg_sel_w = (tgt_w == TGT_REG);

  iram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk   (clk),
    .we    (req_wr && ram_sel_w),
    .waddr (req_addr),
    .wdata (req_wdata),
    .re    (req_rd && ram_sel_w),
    .raddr (req_addr),
    .rdata (ram_q)
  );

  assign sfr_addr  = req_addr;
  assign sfr_wdata = req_wdata;
  assign sfr_rd    = req_rd && reg_sel_w;
  assign sfr_wr    = req_wr && reg_sel_w;

  iram_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (req_rd),
    .tgt       (tgt_w),
    .reg_rdata (sfr_rdata),
    .ram_rdata (ram_q),
    .valid     (rd_valid),
    .data      (rd_data)
  );
endmodule

// File: rtl/iram_overlay_chk.sv
module iram_overlay_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_indirect,
  input logic              req_rd,
  input logic              req_wr,
  input logic              sfr_rd,
  input logic              sfr_wr,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              sfr_hit
);
  AST_LOW_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_addr[ADDR_W-1] |-> (!sfr_rd && !sfr_wr)); // R2
  AST_INDIRECT_NO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    req_indirect |-> (!sfr_rd && !sfr_wr)); // R3
  AST_DIRECT_WR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !req_indirect && sfr_hit) |-> sfr_wr); // R4
  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> rd_valid); // R5
  AST_RD_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> !rd_valid); // R5
  AST_VOID_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr[ADDR_W-1] && !req_indirect && !sfr_hit) |-> (!sfr_rd && !sfr_wr)); // R6
  AST_VOID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && req_addr[ADDR_W-1] && !req_indirect && !sfr_hit) |=> (rd_data == '0)); // R6
  AST_DIRECT_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_indirect && sfr_hit) |-> sfr_rd); // R8
endmodule

bind iram_overlay iram_overlay_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_addr     (req_addr),
  .req_indirect (req_indirect),
  .req_rd       (req_rd),
  .req_wr       (req_wr),
  .sfr_rd       (sfr_rd),
  .sfr_wr       (sfr_wr),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .sfr_hit      (sfr_hit_w)
);

// File: tb/iram_overlay_bench.sv
`timescale 1ns/1ps
module iram_overlay_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_addr = '0;
  logic       req_indirect = 1'b0;
  logic       req_rd = 1'b0;
  logic       req_wr = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [7:0] sfr_addr;
  logic       sfr_rd;
  logic       sfr_wr;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;

  int checks = 0;
  int failures = 0;
  int wr_seen = 0;
  int rd_seen = 0;
  logic [7:0] last_wa = '0;
  logic [7:0] last_wd = '0;
  bit done = 0;

  always #4 clk = ~clk;

  // Register-port model: a read returns the address XOR 5AH.
  assign sfr_rdata = sfr_addr ^ 8'h5A;

  iram_overlay u_iram_overlay (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_indirect(req_indirect),
    .req_rd(req_rd), .req_wr(req_wr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sfr_addr(sfr_addr),
    .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  always @(posedge clk) begin
    if (sfr_wr) begin
      wr_seen <= wr_seen + 1;
      last_wa <= sfr_addr;
      last_wd <= sfr_wdata;
    end
    if (sfr_rd) rd_seen <= rd_seen + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic ind, input logic [7:0] d);
    @(negedge clk);
    req_addr = a; req_indirect = ind; req_wr = 1'b1; req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic ind, output logic [7:0] d);
    @(negedge clk);
    req_addr = a; req_indirect = ind; req_rd = 1'b1;
    @(negedge clk);
    req_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset;
    check("R1 rd_valid", rd_valid, 0);
    check("R1 rd_data", rd_data, 8'h00);
  endtask

  task automatic t_low;
    logic [7:0] d;
    int w0 = wr_seen;
    wr(8'h10, 1'b0, 8'hA5); rd(8'h10, 1'b1, d);
    check("R2 direct->indirect", d, 8'hA5);
    wr(8'h7F, 1'b1, 8'h5C); rd(8'h7F, 1'b0, d);
    check("R2 indirect->direct", d, 8'h5C);
    check("R2 no port write", wr_seen, w0);
  endtask

  task automatic t_upper;
    logic [7:0] d;
    int w0 = wr_seen;
    wr(8'hA0, 1'b1, 8'h3C);
    check("R3 no port write", wr_seen, w0);
    wr(8'hA0, 1'b0, 8'h99);
    check("R4 port write count", wr_seen, w0 + 1);
    check("R4 port addr", last_wa, 8'hA0);
    check("R4 port data", last_wd, 8'h99);
    rd(8'hA0, 1'b1, d);
    check("R4 upper RAM intact", d, 8'h3C);
    check("R3 indirect readback", d, 8'h3C);
  endtask

  task automatic t_latency;
    @(negedge clk);
    req_addr = 8'h10; req_indirect = 1'b0; req_rd = 1'b1;
    check("R5 not valid in request cycle", rd_valid, 0);
    @(negedge clk);
    req_rd = 1'b0;
    check("R5 valid next cycle", rd_valid, 1);
    check("R5 data", rd_data, 8'hA5);
    @(negedge clk);
    check("R5 valid drops", rd_valid, 0);
  endtask

  task automatic t_void;
    logic [7:0] d;
    int w0 = wr_seen;
    int r0 = rd_seen;
    wr(8'hC5, 1'b1, 8'h77);
    wr(8'hC5, 1'b0, 8'h12);
    check("R6 no port write", wr_seen, w0);
    rd(8'hC5, 1'b0, d);
    check("R6 reads zero", d, 8'h00);
    check("R6 no port read", rd_seen, r0);
    rd(8'hC5, 1'b1, d);
    check("R6 RAM untouched", d, 8'h77);
  endtask

  task automatic t_same;
    logic [7:0] d;
    wr(8'h20, 1'b1, 8'h11);
    @(negedge clk);
    req_addr = 8'h20; req_indirect = 1'b1; req_rd = 1'b1; req_wr = 1'b1; req_wdata = 8'h22;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    check("R7 old byte", rd_data, 8'h11);
    rd(8'h20, 1'b1, d);
    check("R7 new byte", d, 8'h22);
  endtask

  task automatic t_regread;
    logic [7:0] d;
    int r0 = rd_seen;
    rd(8'hD0, 1'b0, d);
    check("R8 port read data", d, 8'hD0 ^ 8'h5A);
    check("R8 port read strobe", rd_seen, r0 + 1);
  endtask

  task automatic t_stack;
    logic [7:0] d;
    int bad = 0;
    for (int i = 128; i < 256; i++) wr(8'(i), 1'b1, 8'(i) ^ 8'hC3);
    for (int i = 255; i >= 128; i--) begin
      rd(8'(i), 1'b1, d);
      if (d !== (8'(i) ^ 8'hC3)) bad++;
    end
    check("R9 stack fill mismatches", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_low();
    t_upper();
    t_latency();
    t_void();
    t_same();
    t_regread();
    t_stack();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule